// File: doc/BRIEF.md
# Interlaced Field Timing Sequencer

This block produces the vertical timing of an interlaced raster that alternates two fields. A horizontal timer supplies a one-cycle `lineTick` once per scan line. The block keeps a signed position counter in half-line units that climbs by two on every tick of the vertical interval. It drives a blanking output and a vertical-sync output from that counter. The visible region that follows is a parameterised number of lines long.

The two fields get different blanking lengths and sync start points, chosen so that their parities differ. On the field that carries the odd scan lines, the counter starts one half-line further below zero. That field therefore blanks for one more line, and its sync edges fall half a line later relative to the raster. This offset interlaces the two fields.

At the end of each field the odd-field flag is complemented, and it selects the constants for the next vertical interval. A one-cycle pulse marks the first visible line so software can take a frame interrupt.

Top module: `ilaceFieldSeq`

## Requirements
- R1: While `rstN` is low and in the cycle after it, the outputs show vertical blanking of the odd field: `vBlank`=1, `vSync`=0, `oddField`=1, `fieldStart`=0.
- R2: A cycle with `lineTick`=0 changes none of `vBlank`, `vSync`, `oddField`, and leaves `fieldStart` at 0.
- R3: On the odd field (`oddField`=1), with default constants, `vSync` rises on the 3rd tick of the vertical interval and falls on the 19th. In general these are the ticks where the position −69+2k reaches −63 and −31.
- R4: On the even field (`oddField`=0), with default constants, `vSync` rises on the 2nd tick of the vertical interval and falls on the 18th. These are the ticks where the position −68+2k reaches −64 and −32.
- R5: Vertical blanking ends on the tick where the position first becomes non-negative. That is the 35th tick on the odd field and the 34th on the even field.
- R6: `fieldStart` is high for exactly one cycle, in the cycle after the tick that ends blanking, and at no other time.
- R7: The visible region lasts `VIS_LINES` ticks. On the last of them, `vBlank` is set again and `oddField` is complemented.
- R8: `vSync` is never high while `vBlank` is low.
- R9: Fields alternate strictly: odd, even, odd, and so on, starting with odd after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineTick | input | 1 | One-cycle pulse per scan line from the horizontal timer |
| vBlank | output | 1 | Vertical blanking, 1 during the vertical interval |
| vSync | output | 1 | Vertical sync, 1 inside the blanking window |
| oddField | output | 1 | 1 while the odd-line field (longer blanking) is current |
| fieldStart | output | 1 | One-cycle pulse at the first visible line |

## Verification
The hardest situation to reach is the interplay between the two fields' parities. The odd field is the only place where blanking ends on a positive position rather than exactly at zero. The even field is the only place where the sync edges land on even positions. Both fields must also be seen in succession, with the first-field-after-reset special case. The stimulus therefore runs several complete field pairs using a shortened visible region, with random idle gaps between ticks. It then forces a reset in the middle of an even-field interval to check that the sequencer returns to the odd timing rather than continuing with the even timing.

// File: rtl/ilaceFieldSeq_pkg.sv
package ilaceFieldSeq_pkg;

  typedef enum logic {
    ST_BLANK = 1'b0,
    ST_VIS   = 1'b1
  } seqState_t;

  // strobes from control into the position/visible datapath
  typedef struct packed {
    logic loadY;    // reload position for a new vertical interval
    logic stepY;    // advance position by two half-lines
    logic loadVis;  // load visible line count
    logic stepVis;  // count down one visible line
    logic oddSel;   // field whose constants apply to loadY
  } seqStrobe_t;

endpackage

// File: rtl/ilaceFieldSeqData.sv
module ilaceFieldSeqData
  import ilaceFieldSeq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int VIS_LINES   = 403,
  parameter int BLANK_B     = 68,
  parameter int BLANK_EXTRA = 1,
  parameter int SYNC_A      = 63,
  parameter int SYNC_B      = 64,
  parameter int SYNC_LEN    = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  input  logic       oddField,
  output logic       syncOnHit,
  output logic       syncOffHit,
  output logic       blankEnd,
  output logic       visLast
);

  localparam int VIS_W   = $clog2(VIS_LINES + 1);
  localparam int BLANK_A = BLANK_B + BLANK_EXTRA;
  localparam int INIT_A  = -BLANK_A;
  localparam int INIT_B  = -BLANK_B;
  localparam int ON_A    = -SYNC_A;
  localparam int ON_B    = -SYNC_B;
  localparam int OFF_A   = SYNC_LEN - SYNC_A;
  localparam int OFF_B   = SYNC_LEN - SYNC_B;

  logic [CNT_W-1:0] posY;
  logic [CNT_W-1:0] posNext;
  logic [VIS_W-1:0] visCnt;
  logic [CNT_W-1:0] onMark;
  logic [CNT_W-1:0] offMark;

  assign posNext = posY + CNT_W'(2);

  // per-field compare points, both expressed as positions below zero
  always_comb begin
    if (oddField) begin
      onMark  = CNT_W'(ON_A);
      offMark = CNT_W'(OFF_A);
    end else begin
      onMark  = CNT_W'(ON_B);
      offMark = CNT_W'(OFF_B);
    end
  end

  assign syncOnHit  = (posNext == onMark);
  assign syncOffHit = (posNext == offMark);
  assign blankEnd   = ~posNext[CNT_W-1];
  assign visLast    = (visCnt == VIS_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posY <= CNT_W'(INIT_A);
    end else if (strb.loadY) begin
      posY <= strb.oddSel ? CNT_W'(INIT_A) : CNT_W'(INIT_B);
    end else if (strb.stepY) begin
      posY <= posNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      visCnt <= '0;
    end else if (strb.loadVis) begin
      visCnt <= VIS_W'(VIS_LINES);
    end else if (strb.stepVis) begin
      visCnt <= visCnt - VIS_W'(1);
    end
  end

endmodule

// File: rtl/ilaceFieldSeqCtrl.sv
module ilaceFieldSeqCtrl
  import ilaceFieldSeq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineTick,
  input  logic       syncOnHit,
  input  logic       syncOffHit,
  input  logic       blankEnd,
  input  logic       visLast,
  output seqStrobe_t strb,
  output logic       oddField,
  output logic       vBlank,
  output logic       vSync,
  output logic       fieldStart
);

  seqState_t state;
  logic      oddQ;
  logic      syncQ;
  logic      startQ;

  always_comb begin
    strb        = '0;
    strb.oddSel = oddQ;
    if (lineTick) begin
      case (state)
        ST_BLANK: begin
          strb.stepY   = 1'b1;
          strb.loadVis = blankEnd;
        end
        ST_VIS: begin
          if (visLast) begin
            strb.loadY  = 1'b1;
            strb.oddSel = ~oddQ;
          end else begin
            strb.stepVis = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_BLANK;
      oddQ   <= 1'b1;
      syncQ  <= 1'b0;
      startQ <= 1'b0;
    end else begin
      startQ <= 1'b0;
      if (lineTick) begin
        case (state)
          ST_BLANK: begin
            if (blankEnd) begin
              state  <= ST_VIS;
              syncQ  <= 1'b0;
              startQ <= 1'b1;
            end else if (syncOnHit) begin
              syncQ <= 1'b1;
            end else if (syncOffHit) begin
              syncQ <= 1'b0;
            end
          end
          ST_VIS: begin
            if (visLast) begin
              state <= ST_BLANK;
              oddQ  <= ~oddQ;
            end
          end
          default: state <= ST_BLANK;
        endcase
      end
    end
  end

  assign oddField   = oddQ;
  assign vBlank     = (state == ST_BLANK);
  assign vSync      = syncQ;
  assign fieldStart = startQ;

endmodule

// File: rtl/ilaceFieldSeq.sv
module ilaceFieldSeq
  import ilaceFieldSeq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int VIS_LINES   = 403,
  parameter int BLANK_B     = 68,
  parameter int BLANK_EXTRA = 1,
  parameter int SYNC_A      = 63,
  parameter int SYNC_B      = 64,
  parameter int SYNC_LEN    = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineTick,
  output logic vBlank,
  output logic vSync,
  output logic oddField,
  output logic fieldStart
);

  seqStrobe_t strb;
  logic       syncOnHit;
  logic       syncOffHit;
  logic       blankEnd;
  logic       visLast;

  ilaceFieldSeqCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .lineTick   (lineTick),
    .syncOnHit  (syncOnHit),
    .syncOffHit (syncOffHit),
    .blankEnd   (blankEnd),
    .visLast    (visLast),
    .strb       (strb),
    .oddField   (oddField),
    .vBlank     (vBlank),
    .vSync      (vSync),
    .fieldStart (fieldStart)
  );

  ilaceFieldSeqData #(
    .CNT_W       (CNT_W),
    .VIS_LINES   (VIS_LINES),
    .BLANK_B     (BLANK_B),
    .BLANK_EXTRA (BLANK_EXTRA),
    .SYNC_A      (SYNC_A),
    .SYNC_B      (SYNC_B),
    .SYNC_LEN    (SYNC_LEN)
  ) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .oddField   (oddField),
    .syncOnHit  (syncOnHit),
    .syncOffHit (syncOffHit),
    .blankEnd   (blankEnd),
    .visLast    (visLast)
  );

endmodule

// File: rtl/ilaceFieldSeqChk.sv
module ilaceFieldSeqChk (
  input logic clk,
  input logic rstN,
  input logic lineTick,
  input logic vBlank,
  input logic vSync,
  input logic oddField,
  input logic fieldStart
);

  // R8: sync only inside blanking
  assert_sync_in_blank_R8: assert property (@(posedge clk) disable iff (!rstN)
    vSync |-> vBlank);

  // R6: pulse is one cycle wide
  assert_start_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart |=> !fieldStart);

  // R6: pulse only where blanking has just ended
  assert_start_at_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart |-> (!vBlank && $past(vBlank)));

  // R2: no tick, no change
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(lineTick) |-> ($stable(vBlank) && $stable(vSync) && $stable(oddField) && !fieldStart));

  // R7: new vertical interval flips the field flag
  assert_field_toggle_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vBlank) |-> (oddField != $past(oddField)));

  // R9: the field flag only changes when blanking starts
  assert_field_change_R9: assert property (@(posedge clk) disable iff (!rstN)
    (oddField != $past(oddField)) |-> $rose(vBlank));

endmodule

bind ilaceFieldSeq ilaceFieldSeqChk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .lineTick   (lineTick),
  .vBlank     (vBlank),
  .vSync      (vSync),
  .oddField   (oddField),
  .fieldStart (fieldStart)
);

// File: tb/ilaceFieldSeq_tb_top.sv
`timescale 1ns/1ps
module ilaceFieldSeq_tb_top;

  localparam int TB_VIS   = 7;
  localparam int BLANK_B  = 68;
  localparam int BLANK_X  = 1;
  localparam int SYNC_A   = 63;
  localparam int SYNC_B   = 64;
  localparam int SYNC_LEN = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineTick = 1'b0;
  logic vBlank, vSync, oddField, fieldStart;

  always #2 clk = ~clk;

  ilaceFieldSeq #(.VIS_LINES(TB_VIS)) dut_i (
    .clk(clk), .rstN(rstN), .lineTick(lineTick),
    .vBlank(vBlank), .vSync(vSync), .oddField(oddField), .fieldStart(fieldStart)
  );

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  // expected model state
  bit expBlank, expSync, expOdd, expFs;
  int kTick, visN;

  function automatic int ceilHalf(int n);
    return (n + 1) / 2;
  endfunction
  function automatic int blankLen(bit odd);
    return odd ? BLANK_B + BLANK_X : BLANK_B;
  endfunction
  function automatic int syncOnTick(bit odd);
    return ceilHalf(blankLen(odd) - (odd ? SYNC_A : SYNC_B));
  endfunction
  function automatic int syncOffTick(bit odd);
    return ceilHalf(blankLen(odd) - (odd ? SYNC_A : SYNC_B) + SYNC_LEN);
  endfunction
  function automatic int blankEndTick(bit odd);
    return ceilHalf(blankLen(odd));
  endfunction

  task automatic chk(string req, string name, logic act, logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0b expected=%0b (t=%0t)", req, name, act, exp, $time);
    end
  endtask

  task automatic checkAll(string blankReq);
    chk(blankReq, "vBlank", vBlank, expBlank);
    chk(expOdd ? "R3" : "R4", "vSync", vSync, expSync);
    chk("R9", "oddField", oddField, expOdd);
    chk("R6", "fieldStart", fieldStart, expFs);
  endtask

  task automatic modelReset();
    expBlank = 1'b1; expSync = 1'b0; expOdd = 1'b1; expFs = 1'b0;
    kTick = 0; visN = 0;
  endtask

  task automatic doTick();
    string req;
    @(negedge clk) lineTick = 1'b1;
    @(negedge clk) lineTick = 1'b0;
    expFs = 1'b0;
    if (expBlank) begin
      kTick++;
      req = "R5";
      if (kTick == blankEndTick(expOdd)) begin
        expBlank = 1'b0; expSync = 1'b0; expFs = 1'b1; visN = 0;
      end else begin
        expSync = (kTick >= syncOnTick(expOdd)) && (kTick < syncOffTick(expOdd));
      end
    end else begin
      visN++;
      req = "R7";
      if (visN == TB_VIS) begin
        expBlank = 1'b1; expOdd = ~expOdd; kTick = 0; expSync = 1'b0;
      end
    end
    checkAll(req);
    expFs = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkAll("R2");
    end
  endtask

  task automatic runTicks(int n, int maxGap);
    for (int i = 0; i < n; i++) begin
      doTick();
      idle($urandom_range(maxGap, 0));
    end
  endtask

  task automatic finish();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(negedge clk);
    checkAll("R1");                       // R1 during reset
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");                       // R1 after release
    idle(20);                             // R2 long idle in blanking

    // R3/R5/R6/R7 odd field, then R4 even field, repeated: R9 alternation
    runTicks(4 * (35 + TB_VIS), 3);

    // directed: back-to-back ticks across a full field pair
    runTicks(2 * (35 + TB_VIS), 0);

    // directed: reset in the middle of an even-field interval
    while (!(expBlank && !expOdd && kTick == 10)) doTick();
    chk("R4", "vSync mid-even", vSync, 1'b1);
    @(negedge clk) rstN = 1'b0;
    modelReset();
    repeat (2) @(negedge clk);
    checkAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");
    runTicks(2 * (35 + TB_VIS) + 5, 2);   // R9: restarts with odd timing
    idle(15);                             // R2 in visible or blanking
    finished = 1'b1;
    finish();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish();
    end
  end

endmodule